// File: doc/BRIEF.md
# Output-to-Store Spacing Hazard Checker

This block watches the instruction stream that a microcoded task issues, one instruction per valid cycle. An I/O output operation takes up a register-file slot in a later memory-controller stage. A 4-word store, or a task return that hands the pipeline to another task, can collide with that slot if it comes too soon after the output. The block flags such a collision and reports how many more instructions are still needed before the spacing is safe.

The spacing needed after an output depends on the memory instruction that came before the output, and on how many non-memory instructions lay between the two. A preceding I/O fetch of either length, or a preceding output, delays the output inside the memory pipeline, so the spacing after it must be longer. When a task has issued no memory reference since its last return, the block assumes the worst case. A register read placed directly after the output, used as an interlock, stalls the processor until the output finishes, and this removes the need for any further spacing.

Top module: `outstore_gap_check`

## Requirements
- R1: After reset `hazard_viol` is 0 and `gap_left` is 0.
- R2: Op codes on `instr_op`: 0 non-memory, 1 I/O fetch 4, 2 I/O fetch 16, 3 output, 4 four-word store, 5 other memory, and 6 or 7 also other memory. An output whose most recent earlier memory instruction was a store, or another memory op of any kind except an I/O fetch or an output, loads `gap_left` with 2.
- R3: An output preceded by an I/O fetch 4 or by an output loads 5 when the number of non-memory instructions between them is 2 or fewer. It loads 4 for 3, 3 for 4, and 2 for 5 or more.
- R4: An output preceded by an I/O fetch 16 loads 5 when 8 or fewer non-memory instructions lie between them. It loads 4 for 9, 3 for 10, and 2 for 11 or more.
- R5: An output with no memory instruction since reset or since the last task return loads 5.
- R6: The count of non-memory instructions between two memory instructions saturates at 15, so a very long run gives the same result as 15, and every memory instruction restarts the count at 0.
- R7: A four-word store that issues while `gap_left` is nonzero is a violation. A store does not lower `gap_left`.
- R8: A task return is a violation unless it issues on or after the required instruction. A return on a non-memory instruction is a violation when `gap_left` exceeds 1, and a return on a memory instruction is a violation when `gap_left` exceeds 0.
- R9: Each valid non-memory instruction lowers a nonzero `gap_left` by 1. A memory instruction other than an output leaves it unchanged.
- R10: `instr_interlock` on a non-memory instruction that directly follows an output clears the requirement, and that instruction is then checked against a gap of 0. On any other instruction the flag is ignored.
- R11: A task return clears the history: `gap_left` becomes 0 and the next output is treated as in R5.
- R12: `hazard_viol` is high for exactly the one cycle after each offending instruction. A cycle with `instr_valid` low changes neither `gap_left` nor the history and never raises `hazard_viol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | An instruction issues this cycle |
| instr_op | input | 3 | Opcode class of the issuing instruction |
| instr_task_ret | input | 1 | The instruction carries a task return |
| instr_interlock | input | 1 | The instruction reads the output's register (interlock) |
| hazard_viol | output | 1 | One-cycle pulse after a too-close store or return |
| gap_left | output | 3 | Instructions still needed before a store is safe |

## Verification
Both results are registered. After an instruction is presented at a clock edge, `hazard_viol` and `gap_left` show its effect from that edge until the next one. The bench drives each instruction on the falling edge and samples 1 ns after the following rising edge, so every sample sits one register stage downstream of its own instruction. A reference model in the bench is updated at the same point in each step, using the spacing tables written out literally, so each sample is compared against the value due in that exact cycle.

// File: rtl/ohz_pkg.sv
package ohz_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NONMEM   = 3'd0,
    OP_IOF4     = 3'd1,
    OP_IOF16    = 3'd2,
    OP_OUTPUT   = 3'd3,
    OP_STORE4   = 3'd4,
    OP_MEMOTHER = 3'd5
  } op_e;

  // kind of the most recent memory instruction since the last task return
  typedef enum logic [1:0] {
    PK_NONE  = 2'd0,
    PK_SHORT = 2'd1,   // I/O fetch 4 or output
    PK_LONG  = 2'd2,   // I/O fetch 16
    PK_PLAIN = 2'd3    // any other memory instruction
  } prev_e;

  function automatic logic op_is_mem(input logic [OP_W-1:0] op);
    return op != OP_NONMEM;
  endfunction

  function automatic prev_e op_kind(input logic [OP_W-1:0] op);
    case (op)
      OP_IOF4, OP_OUTPUT: return PK_SHORT;
      OP_IOF16:           return PK_LONG;
      default:            return PK_PLAIN;
    endcase
  endfunction

endpackage

// File: rtl/ohz_history.sv
module ohz_history
  import ohz_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [OP_W-1:0] op_i,
  input  logic            ret_i,
  output prev_e           kind_o,
  output logic [CNT_W-1:0] nm_cnt_o
);

  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

  prev_e            kind_q, kind_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  assign en = valid_i;

  always_comb begin
    kind_d = kind_q;
    cnt_d  = cnt_q;
    if (ret_i) begin
      kind_d = PK_NONE;
      cnt_d  = '0;
    end else if (!op_is_mem(op_i)) begin
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end else begin
      kind_d = op_kind(op_i);
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= PK_NONE;
      cnt_q  <= '0;
    end else if (en) begin
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
    end
  end

  assign kind_o   = kind_q;
  assign nm_cnt_o = cnt_q;

endmodule

// File: rtl/ohz_gap_calc.sv
module ohz_gap_calc
  import ohz_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int GAP_MIN  = 2,
  parameter int GAP_MAX  = 5,
  parameter int F4_KNEE  = 2,
  parameter int F16_KNEE = 8,
  localparam int GAP_W   = $clog2(GAP_MAX + 1)
) (
  input  prev_e            kind_i,
  input  logic [CNT_W-1:0] nm_cnt_i,
  output logic [GAP_W-1:0] req_o
);

  localparam int SPAN = GAP_MAX - GAP_MIN;

  // requirement shrinks by one per non-memory instruction past the knee
  function automatic logic [GAP_W-1:0] ramp(input int cnt, input int knee);
    int over;
    if (cnt <= knee) return GAP_W'(GAP_MAX);
    over = cnt - knee;
    if (over >= SPAN) return GAP_W'(GAP_MIN);
    return GAP_W'(GAP_MAX - over);
  endfunction

  always_comb begin
    case (kind_i)
      PK_NONE:  req_o = ramp(0, F16_KNEE);
      PK_SHORT: req_o = ramp(int'(nm_cnt_i), F4_KNEE);
      PK_LONG:  req_o = ramp(int'(nm_cnt_i), F16_KNEE);
      default:  req_o = GAP_W'(GAP_MIN);
    endcase
  end

endmodule

// File: rtl/ohz_window.sv
module ohz_window
  import ohz_pkg::*;
#(
  parameter int GAP_MAX = 5,
  localparam int GAP_W  = $clog2(GAP_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic             ret_i,
  input  logic             il_i,
  input  logic [GAP_W-1:0] req_i,
  output logic [GAP_W-1:0] rem_o,
  output logic             viol_o
);

  logic [GAP_W-1:0] rem_q, rem_d, eff;
  logic             just_q, just_d;
  logic             viol_q, viol_d;
  logic             is_nm, is_out, is_st, il_ok, ret_bad, st_bad;

  assign is_nm  = !op_is_mem(op_i);
  assign is_out = op_i == OP_OUTPUT;
  assign is_st  = op_i == OP_STORE4;
  assign il_ok  = just_q && is_nm && il_i;
  assign eff    = il_ok ? '0 : rem_q;

  // a return on a non-memory instruction counts as one of the gap
  assign ret_bad = ret_i && (is_nm ? (eff > GAP_W'(1)) : (eff != '0));
  assign st_bad  = is_st && (eff != '0);

  always_comb begin
    viol_d = valid_i && (ret_bad || st_bad);
    rem_d  = rem_q;
    just_d = just_q;
    if (valid_i) begin
      just_d = is_out && !ret_i;
      if (ret_i)            rem_d = '0;
      else if (is_out)      rem_d = req_i;
      else if (is_nm)       rem_d = (eff == '0) ? '0 : eff - 1'b1;
      else                  rem_d = eff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      just_q <= 1'b0;
    end else if (valid_i) begin
      rem_q  <= rem_d;
      just_q <= just_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= viol_d;
  end

  assign rem_o  = rem_q;
  assign viol_o = viol_q;

endmodule

// File: rtl/outstore_gap_check.sv
module outstore_gap_check
  import ohz_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int GAP_MIN  = 2,
  parameter int GAP_MAX  = 5,
  parameter int F4_KNEE  = 2,
  parameter int F16_KNEE = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         instr_valid,
  input  logic [2:0]                   instr_op,
  input  logic                         instr_task_ret,
  input  logic                         instr_interlock,
  output logic                         hazard_viol,
  output logic [$clog2(GAP_MAX+1)-1:0] gap_left
);

  localparam int GAP_W = $clog2(GAP_MAX + 1);

  prev_e            kind;
  logic [CNT_W-1:0] nm_cnt;
  logic [GAP_W-1:0] req;

  ohz_history #(.CNT_W(CNT_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (instr_valid),
    .op_i     (instr_op),
    .ret_i    (instr_task_ret),
    .kind_o   (kind),
    .nm_cnt_o (nm_cnt)
  );

  ohz_gap_calc #(
    .CNT_W(CNT_W), .GAP_MIN(GAP_MIN), .GAP_MAX(GAP_MAX),
    .F4_KNEE(F4_KNEE), .F16_KNEE(F16_KNEE)
  ) u_calc (
    .kind_i   (kind),
    .nm_cnt_i (nm_cnt),
    .req_o    (req)
  );

  ohz_window #(.GAP_MAX(GAP_MAX)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (instr_valid),
    .op_i    (instr_op),
    .ret_i   (instr_task_ret),
    .il_i    (instr_interlock),
    .req_i   (req),
    .rem_o   (gap_left),
    .viol_o  (hazard_viol)
  );

endmodule

// File: rtl/ohz_checker.sv
module ohz_checker #(
  parameter int GAP_MIN = 2,
  parameter int GAP_MAX = 5,
  localparam int GAP_W  = $clog2(GAP_MAX + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_valid,
  input logic [2:0]       instr_op,
  input logic             instr_task_ret,
  input logic             instr_interlock,
  input logic             hazard_viol,
  input logic [GAP_W-1:0] gap_left
);

  // R12: a pulse only follows an issued store or return
  a_r12_viol_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hazard_viol) |-> $past(instr_valid && (instr_op == 3'd4 || instr_task_ret)));

  // R12: idle cycles change nothing
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> $stable(gap_left) && !hazard_viol);

  // R11: a return empties the window
  a_r11_ret_clear: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && instr_task_ret |=> gap_left == '0);

  // R3: an output loads a requirement within the legal range
  a_r3_load_range: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && instr_op == 3'd3 && !instr_task_ret
      |=> gap_left >= GAP_W'(GAP_MIN) && gap_left <= GAP_W'(GAP_MAX));

  // R9: a plain non-memory instruction counts the gap down by one
  a_r9_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && instr_op == 3'd0 && !instr_task_ret && !instr_interlock && gap_left != '0
      |=> gap_left == $past(gap_left) - 1'b1);

  // R7: a store never lowers the gap
  a_r7_store_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && instr_op == 3'd4 && !instr_task_ret |=> $stable(gap_left));

  // R7: a store on a nonzero gap raises the pulse
  a_r7_store_flag: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && instr_op == 3'd4 && gap_left != '0 |=> hazard_viol);

endmodule

bind outstore_gap_check ohz_checker #(.GAP_MIN(GAP_MIN), .GAP_MAX(GAP_MAX)) u_ohz_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .instr_valid     (instr_valid),
  .instr_op        (instr_op),
  .instr_task_ret  (instr_task_ret),
  .instr_interlock (instr_interlock),
  .hazard_viol     (hazard_viol),
  .gap_left        (gap_left)
);

// File: tb/outstore_gap_check_tb.sv
`timescale 1ns/1ps
module outstore_gap_check_tb;

  localparam int NM = 0, F4 = 1, F16 = 2, OUT = 3, ST = 4, MO = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       v = 1'b0;
  logic [2:0] op = '0;
  logic       ret = 1'b0;
  logic       il = 1'b0;
  logic       viol;
  logic [2:0] gap;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state: 0 none, 1 fetch4/output, 2 fetch16, 3 other
  int m_kind = 0, m_cnt = 0, m_rem = 0;
  bit m_just = 0;
  bit m_viol = 0;

  always #4 clk = ~clk;

  outstore_gap_check u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(v), .instr_op(op),
    .instr_task_ret(ret), .instr_interlock(il),
    .hazard_viol(viol), .gap_left(gap)
  );

  function automatic int spacing(input int kind, input int cnt);
    case (kind)
      0: return 5;
      1: if (cnt <= 2) return 5; else if (cnt == 3) return 4;
         else if (cnt == 4) return 3; else return 2;
      2: if (cnt <= 8) return 5; else if (cnt == 9) return 4;
         else if (cnt == 10) return 3; else return 2;
      default: return 2;
    endcase
  endfunction

  task automatic model(input bit vv, input int o, input bit r, input bit l);
    int  e;
    bit  mem;
    m_viol = 0;
    if (!vv) return;
    mem = (o != NM);
    e = (m_just && !mem && l) ? 0 : m_rem;
    if (o == ST && e > 0) m_viol = 1;
    if (r && (mem ? e > 0 : e > 1)) m_viol = 1;
    if (r)             m_rem = 0;
    else if (o == OUT) m_rem = spacing(m_kind, m_cnt);
    else if (!mem)     m_rem = (e > 0) ? e - 1 : 0;
    else               m_rem = e;
    m_just = (o == OUT) && !r;
    if (r) begin m_kind = 0; m_cnt = 0; end
    else if (!mem) begin if (m_cnt < 15) m_cnt++; end
    else begin
      m_cnt = 0;
      m_kind = (o == F4 || o == OUT) ? 1 : (o == F16) ? 2 : 3;
    end
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (viol !== m_viol || gap !== 3'(m_rem)) begin
      n_bad++;
      $display("FAIL %s: viol=%0b gap=%0d expected viol=%0b gap=%0d",
               tag, viol, gap, m_viol, m_rem);
    end
  endtask

  task automatic step(input bit vv, input int o, input bit r, input bit l, input string tag);
    @(negedge clk);
    v = vv; op = 3'(o); ret = r; il = l;
    model(vv, o, r, l);
    @(posedge clk);
    #1;
    check(tag);
  endtask

  task automatic nms(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, NM, 0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1;
    check("R1");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1");

    step(1, NM, 1, 0, "R11");
    step(1, OUT, 0, 0, "R5");          // no reference since return -> 5
    nms(4, "R9");                      // 4,3,2,1
    step(1, MO, 0, 0, "R9");           // memory op leaves 1
    step(1, ST, 0, 0, "R7");           // store on nonzero gap
    step(0, NM, 0, 0, "R12");          // idle: pulse gone, gap held
    step(1, NM, 0, 0, "R9");
    step(1, ST, 0, 0, "R7");           // gap 0: no violation
    step(1, NM, 0, 0, "R2");
    step(1, OUT, 0, 0, "R2");          // preceded by store -> 2
    step(1, NM, 0, 0, "R8");
    step(1, NM, 1, 0, "R8");           // return on 2nd instruction: legal
    step(1, OUT, 0, 0, "R5");
    step(1, NM, 0, 0, "R8");
    step(1, NM, 1, 0, "R8");           // too early: violation
    step(1, NM, 0, 0, "R12");          // single-cycle pulse

    step(1, F4, 0, 0, "R3");  nms(3, "R3"); step(1, OUT, 0, 0, "R3");   // 4
    step(1, F4, 0, 0, "R3");  nms(5, "R3"); step(1, OUT, 0, 0, "R3");   // 2
    step(1, OUT, 0, 0, "R3"); nms(2, "R3"); step(1, OUT, 0, 0, "R3");   // 5
    nms(5, "R9");
    step(1, F16, 0, 0, "R4"); nms(9, "R4");  step(1, OUT, 0, 0, "R4");  // 4
    step(1, F16, 0, 0, "R4"); nms(10, "R4"); step(1, OUT, 0, 0, "R4");  // 3
    step(1, F16, 0, 0, "R6"); nms(20, "R6"); step(1, OUT, 0, 0, "R6");  // saturated -> 2
    step(1, F16, 0, 0, "R6"); nms(9, "R6"); step(1, MO, 0, 0, "R6");
    step(1, F16, 0, 0, "R6"); step(1, OUT, 0, 0, "R6");                 // restarted -> 5

    step(1, OUT, 0, 0, "R10"); step(1, NM, 0, 1, "R10");  // interlock clears
    step(1, ST, 0, 0, "R10");                             // no violation
    step(1, OUT, 0, 0, "R10"); step(1, NM, 0, 0, "R10");
    step(1, NM, 0, 1, "R10");                             // late interlock ignored
    step(1, ST, 0, 0, "R10");
    step(1, OUT, 0, 0, "R10"); step(1, NM, 1, 1, "R10");  // interlock with return: legal

    for (int i = 0; i < 3000; i++) begin
      int r, o;
      r = int'($urandom % 16);
      o = (r < 9) ? NM : (r == 9) ? F4 : (r == 10) ? F16 :
          (r < 13) ? OUT : (r == 13) ? ST : (r == 14) ? MO : 6;
      step(($urandom % 8) != 0, o, ($urandom % 12) == 0, ($urandom % 4) == 0, "RND");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule